// File: doc/BRIEF.md
# UART Interrupt Cause Collector

This block gathers the interrupt causes of a high-speed UART into one status word and drives a single interrupt line. It has five causes: receiver line status, receive data available, character timeout, transmit space available and modem line change. The FIFOs and the serial engine are outside the block. They report plain one-cycle event pulses and live levels. Each cause is a sticky bit of its own, so several causes can be pending at the same time. There is no single prioritised code.

A host reads the status word, handles every cause it finds, and then writes the same identification bits back through byte lane 0 to clear them. The same byte also carries the top two bits of the receive fill count, and these do not change when written. Clearing the line-status cause also clears the latched receive error flags. Clearing the modem cause also clears the latched line-change flags. A configuration word holds the cause enables, the serial line control and trigger fields, and the modem control outputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `status_word`, `cfg_word` and `irq_o` are all zero while every input is held low.
- R2: Identification bits sit in `status_word[4:0]`: bit 0 line status, bit 1 data available, bit 2 character timeout, bit 3 transmit space, bit 4 modem change. An event sets its bit on the next clock edge. `irq_o` is high exactly when any of these bits is set.
- R3: Enables are in `cfg_word[3:0]`: bit 0 receive (gates both data available and timeout), bit 1 transmit space, bit 2 line status, bit 3 modem. An event whose enable is low sets nothing.
- R4: A set identification bit stays set after its event ends, until the host clears it.
- R5: A write with `stat_be[0]` high clears each identification bit whose position in `stat_wdata[4:0]` is 1 and leaves the others set. Bits [7:5] of the written byte have no effect. A write without lane 0 changes nothing.
- R6: The line byte `status_word[23:16]` is: bit 0 data ready (live), bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break, bit 5 holding register empty (live), bit 6 transmitter empty (live), bit 7 receive FIFO error. The error flags are sticky and clear together with identification bit 0.
- R7: The modem byte `status_word[15:8]` holds change flags for CTS, DSR, RI and DCD in bits 0 to 3. It holds the synchronised levels of the same four lines in bits 4 to 7. Any level change sets its flag. The flags clear together with identification bit 4.
- R8: When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: Configuration writes are per byte lane. Bits 24 to 29 drive `dtr_o`, `rts_o`, `out1_o`, `out2_o`, `loop_o` and `autoflow_o` in that order. Bits [7:4] and [31:30] always read 0.
- R10: The receive fill count appears split: `rx_fill[7:0]` in `status_word[31:24]` and `rx_fill[9:8]` in `status_word[7:6]`. `status_word[5]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Configuration byte lane enables |
| cfg_wdata | input | 32 | Configuration write data |
| stat_we | input | 1 | Status write strobe (clears causes) |
| stat_be | input | 4 | Status byte lane enables |
| stat_wdata | input | 32 | Status write data |
| ev_rx_avail | input | 1 | Receive data available event |
| ev_rx_timeout | input | 1 | Character timeout event |
| ev_tx_space | input | 1 | Transmit space available event |
| err_overrun | input | 1 | Overrun error event |
| err_parity | input | 1 | Parity error event |
| err_framing | input | 1 | Framing error event |
| err_break | input | 1 | Break detected event |
| err_rxfifo | input | 1 | Receive FIFO error event |
| lvl_data_ready | input | 1 | Live data ready level |
| lvl_thr_empty | input | 1 | Live holding register empty level |
| lvl_tx_empty | input | 1 | Live transmitter empty level |
| modem_cts | input | 1 | CTS line, asynchronous |
| modem_dsr | input | 1 | DSR line, asynchronous |
| modem_ri | input | 1 | RI line, asynchronous |
| modem_dcd | input | 1 | DCD line, asynchronous |
| rx_fill | input | FILL_W | Receive FIFO fill count |
| status_word | output | 32 | Status word |
| cfg_word | output | 32 | Configuration word |
| irq_o | output | 1 | Interrupt request |
| dtr_o | output | 1 | DTR control |
| rts_o | output | 1 | RTS control |
| out1_o | output | 1 | OUT1 control |
| out2_o | output | 1 | OUT2 control |
| loop_o | output | 1 | Loopback control |
| autoflow_o | output | 1 | Automatic RTS/CTS flow control enable |

## Verification
Some rules are checked by the assertions on every cycle:
- a receive or transmit cause only rises while its enable was set in the previous cycle;
- a pending timeout cause holds unless lane 0 clears it;
- a transmit-space clear without a coinciding event leaves the bit low;
- the overrun flag only rises after an overrun event;
- the interrupt line follows the identification field.

Other rules need the directed scenarios:
- the exact bit positions of the line and modem bytes;
- the modem synchroniser latency;
- the set-wins race;
- bits [7:5] being immune to writes;
- per-lane configuration writes;
- the split fill count.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
   localparam int unsigned CAUSE_N = 5;

   typedef enum logic [2:0] {
      CZ_LINE    = 3'd0,
      CZ_RDATA   = 3'd1,
      CZ_TIMEOUT = 3'd2,
      CZ_TXSPACE = 3'd3,
      CZ_MODEM   = 3'd4
   } cause_e;

   localparam int unsigned EN_RX    = 0;
   localparam int unsigned EN_TX    = 1;
   localparam int unsigned EN_LINE  = 2;
   localparam int unsigned EN_MODEM = 3;

   localparam int unsigned CFG_DTR  = 24;
   localparam int unsigned CFG_RTS  = 25;
   localparam int unsigned CFG_OUT1 = 26;
   localparam int unsigned CFG_OUT2 = 27;
   localparam int unsigned CFG_LOOP = 28;
   localparam int unsigned CFG_AUTO = 29;

   localparam logic [31:0] CFG_WMASK = 32'h3FFF_FF0F;

   typedef struct packed {
      logic [7:0] fill_lo;
      logic [7:0] line;
      logic [7:0] modem;
      logic [1:0] fill_hi;
      logic       rsvd;
      logic [4:0] id;
   } status_t;
endpackage

// File: rtl/uart_irq_cause.sv
`timescale 1ns/1ps
module uart_irq_cause #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_r <= 1'b0;
            else if (set_i) q_r <= 1'b1;
            else if (clr_i) q_r <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_r <= 1'b0;
            else if (clr_i) q_r <= 1'b0;
            else if (set_i) q_r <= 1'b1;
         end
      end
   endgenerate

   assign q_o = q_r;
endmodule

// File: rtl/uart_irq_lsr.sv
`timescale 1ns/1ps
module uart_irq_lsr #(
   parameter int unsigned ERR_N    = 5,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_N-1:0] err_i,
   input  logic             clr_i,
   output logic [ERR_N-1:0] flags_o,
   output logic             any_o
);
   generate
      if (ERR_N < 1) begin : g_bad_n
         $error("uart_irq_lsr: ERR_N must be at least 1");
      end
      for (genvar e = 0; e < ERR_N; e++) begin : g_flag
         uart_irq_cause #(.SET_WINS(SET_WINS)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (err_i[e]),
            .clr_i (clr_i),
            .q_o   (flags_o[e])
         );
      end
   endgenerate

   assign any_o = |err_i;
endmodule

// File: rtl/uart_irq_modem.sv
`timescale 1ns/1ps
module uart_irq_modem #(
   parameter int unsigned LINES       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SET_WINS    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lines_i,
   input  logic             clr_i,
   output logic [LINES-1:0] level_o,
   output logic [LINES-1:0] delta_o,
   output logic             change_o
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [LINES-1:0] chain_q [SYNC_STAGES];
   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] diff;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("uart_irq_modem: SYNC_STAGES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) chain_q[s] <= '0;
         prev_q <= '0;
      end else begin
         chain_q[0] <= lines_i;
         for (int s = 1; s < SYNC_STAGES; s++) chain_q[s] <= chain_q[s-1];
         prev_q <= chain_q[LAST];
      end
   end

   assign level_o  = chain_q[LAST];
   assign diff     = chain_q[LAST] ^ prev_q;
   assign change_o = |diff;

   generate
      for (genvar l = 0; l < LINES; l++) begin : g_delta
         uart_irq_cause #(.SET_WINS(SET_WINS)) u_delta (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (diff[l]),
            .clr_i (clr_i),
            .q_o   (delta_o[l])
         );
      end
   endgenerate
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int unsigned FILL_W      = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SET_WINS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   input  logic              stat_we,
   input  logic [3:0]        stat_be,
   input  logic [31:0]       stat_wdata,
   input  logic              ev_rx_avail,
   input  logic              ev_rx_timeout,
   input  logic              ev_tx_space,
   input  logic              err_overrun,
   input  logic              err_parity,
   input  logic              err_framing,
   input  logic              err_break,
   input  logic              err_rxfifo,
   input  logic              lvl_data_ready,
   input  logic              lvl_thr_empty,
   input  logic              lvl_tx_empty,
   input  logic              modem_cts,
   input  logic              modem_dsr,
   input  logic              modem_ri,
   input  logic              modem_dcd,
   input  logic [FILL_W-1:0] rx_fill,
   output logic [31:0]       status_word,
   output logic [31:0]       cfg_word,
   output logic              irq_o,
   output logic              dtr_o,
   output logic              rts_o,
   output logic              out1_o,
   output logic              out2_o,
   output logic              loop_o,
   output logic              autoflow_o
);
   localparam int unsigned LANES = 4;
   localparam int unsigned ERR_N = 5;
   localparam int unsigned MLINE = 4;

   generate
      if (FILL_W != 10) begin : g_bad_fill
         $error("uart_irq_ident: FILL_W must be 10 to fit the split status layout");
      end
   endgenerate

   // configuration word, per-lane writes
   logic [31:0] cfg_q;
   generate
      for (genvar b = 0; b < LANES; b++) begin : g_cfg_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_q[8*b +: 8] <= '0;
            else if (cfg_we && cfg_be[b])
               cfg_q[8*b +: 8] <= cfg_wdata[8*b +: 8] & CFG_WMASK[8*b +: 8];
         end
      end
   endgenerate

   // clear strobes from lane 0 of a status write
   logic [CAUSE_N-1:0] id_clr;
   assign id_clr = (stat_we && stat_be[0]) ? stat_wdata[CAUSE_N-1:0] : '0;

   // line status error latches
   logic [ERR_N-1:0] err_flags;
   logic             err_any;
   uart_irq_lsr #(.ERR_N(ERR_N), .SET_WINS(SET_WINS)) u_lsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_i   ({err_rxfifo, err_break, err_framing, err_parity, err_overrun}),
      .clr_i   (id_clr[CZ_LINE]),
      .flags_o (err_flags),
      .any_o   (err_any)
   );

   // modem line change detection: {dcd, ri, dsr, cts}
   logic [MLINE-1:0] m_level;
   logic [MLINE-1:0] m_delta;
   logic             m_change;
   uart_irq_modem #(.LINES(MLINE), .SYNC_STAGES(SYNC_STAGES), .SET_WINS(SET_WINS)) u_modem (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_i  ({modem_dcd, modem_ri, modem_dsr, modem_cts}),
      .clr_i    (id_clr[CZ_MODEM]),
      .level_o  (m_level),
      .delta_o  (m_delta),
      .change_o (m_change)
   );

   // cause set terms
   logic [CAUSE_N-1:0] cz_set;
   logic [CAUSE_N-1:0] cz_q;
   always_comb begin
      cz_set             = '0;
      cz_set[CZ_LINE]    = cfg_q[EN_LINE]  & err_any;
      cz_set[CZ_RDATA]   = cfg_q[EN_RX]    & ev_rx_avail;
      cz_set[CZ_TIMEOUT] = cfg_q[EN_RX]    & ev_rx_timeout;
      cz_set[CZ_TXSPACE] = cfg_q[EN_TX]    & ev_tx_space;
      cz_set[CZ_MODEM]   = cfg_q[EN_MODEM] & m_change;
   end

   generate
      for (genvar c = 0; c < CAUSE_N; c++) begin : g_cause
         uart_irq_cause #(.SET_WINS(SET_WINS)) u_cause (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (cz_set[c]),
            .clr_i (id_clr[c]),
            .q_o   (cz_q[c])
         );
      end
   endgenerate

   // status assembly
   status_t st;
   always_comb begin
      st          = '0;
      st.id       = cz_q;
      st.rsvd     = 1'b0;
      st.fill_hi  = rx_fill[9:8];
      st.modem    = {m_level, m_delta};
      st.line     = {err_flags[4], lvl_tx_empty, lvl_thr_empty, err_flags[3],
                     err_flags[2], err_flags[1], err_flags[0], lvl_data_ready};
      st.fill_lo  = rx_fill[7:0];
   end

   assign status_word = st;
   assign cfg_word    = cfg_q;
   assign irq_o       = |cz_q;
   assign dtr_o       = cfg_q[CFG_DTR];
   assign rts_o       = cfg_q[CFG_RTS];
   assign out1_o      = cfg_q[CFG_OUT1];
   assign out2_o      = cfg_q[CFG_OUT2];
   assign loop_o      = cfg_q[CFG_LOOP];
   assign autoflow_o  = cfg_q[CFG_AUTO];
endmodule

// File: rtl/uart_irq_ident_chk.sv
`timescale 1ns/1ps
module uart_irq_ident_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        stat_we,
   input logic [3:0]  stat_be,
   input logic [31:0] stat_wdata,
   input logic        ev_tx_space,
   input logic        err_overrun,
   input logic [31:0] status_word,
   input logic [31:0] cfg_word,
   input logic        irq_o
);
   // R2
   irq_follows_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[4:0] == 5'd0) |-> !irq_o);

   // R2
   irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status_word[4:0] != 5'd0));

   // R3
   rdata_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_word[1]) |-> $past(cfg_word[0]));

   // R3
   txspace_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_word[3]) |-> $past(cfg_word[1]));

   // R4
   timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[2] && !(stat_we && stat_be[0] && stat_wdata[2])) |=> status_word[2]);

   // R5
   txspace_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && stat_be[0] && stat_wdata[3] && !ev_tx_space) |=> !status_word[3]);

   // R6
   overrun_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_word[17]) |-> $past(err_overrun));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stat_we     (stat_we),
   .stat_be     (stat_be),
   .stat_wdata  (stat_wdata),
   .ev_tx_space (ev_tx_space),
   .err_overrun (err_overrun),
   .status_word (status_word),
   .cfg_word    (cfg_word),
   .irq_o       (irq_o)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic        stat_we = 1'b0;
   logic [3:0]  stat_be = '0;
   logic [31:0] stat_wdata = '0;
   logic        ev_rx_avail = 1'b0, ev_rx_timeout = 1'b0, ev_tx_space = 1'b0;
   logic        err_overrun = 1'b0, err_parity = 1'b0, err_framing = 1'b0;
   logic        err_break = 1'b0, err_rxfifo = 1'b0;
   logic        lvl_data_ready = 1'b0, lvl_thr_empty = 1'b0, lvl_tx_empty = 1'b0;
   logic        modem_cts = 1'b0, modem_dsr = 1'b0, modem_ri = 1'b0, modem_dcd = 1'b0;
   logic [9:0]  rx_fill = '0;
   logic [31:0] status_word, cfg_word;
   logic        irq_o, dtr_o, rts_o, out1_o, out2_o, loop_o, autoflow_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   uart_irq_ident u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .stat_we(stat_we), .stat_be(stat_be), .stat_wdata(stat_wdata),
      .ev_rx_avail(ev_rx_avail), .ev_rx_timeout(ev_rx_timeout), .ev_tx_space(ev_tx_space),
      .err_overrun(err_overrun), .err_parity(err_parity), .err_framing(err_framing),
      .err_break(err_break), .err_rxfifo(err_rxfifo),
      .lvl_data_ready(lvl_data_ready), .lvl_thr_empty(lvl_thr_empty), .lvl_tx_empty(lvl_tx_empty),
      .modem_cts(modem_cts), .modem_dsr(modem_dsr), .modem_ri(modem_ri), .modem_dcd(modem_dcd),
      .rx_fill(rx_fill),
      .status_word(status_word), .cfg_word(cfg_word), .irq_o(irq_o),
      .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
      .loop_o(loop_o), .autoflow_o(autoflow_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [3:0] be, input logic [31:0] d);
      cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
      tick(1);
      cfg_we = 1'b0; cfg_be = '0; cfg_wdata = '0;
   endtask

   task automatic wr_stat(input logic [3:0] be, input logic [31:0] d);
      stat_we = 1'b1; stat_be = be; stat_wdata = d;
      tick(1);
      stat_we = 1'b0; stat_be = '0; stat_wdata = '0;
   endtask

   task automatic t_reset;
      chk("R1 status", status_word, 32'h0);
      chk("R1 cfg", cfg_word, 32'h0);
      chk("R1 irq", {31'd0, irq_o}, 32'd0);
   endtask

   task automatic t_config;
      wr_cfg(4'hF, 32'hFFFF_FFFF);
      chk("R9 write mask", cfg_word, 32'h3FFF_FF0F);
      chk("R9 control outputs", {26'd0, autoflow_o, loop_o, out2_o, out1_o, rts_o, dtr_o}, 32'h3F);
      wr_cfg(4'b1000, 32'h0000_0000);
      chk("R9 lane 3 only", cfg_word, 32'h00FF_FF0F);
      wr_cfg(4'b1000, 32'h0200_0000);
      chk("R9 rts alone", {26'd0, autoflow_o, loop_o, out2_o, out1_o, rts_o, dtr_o}, 32'h02);
      wr_cfg(4'hF, 32'h0000_000F);
   endtask

   task automatic t_causes;
      ev_rx_avail = 1'b1; tick(1); ev_rx_avail = 1'b0;
      chk("R2 data available bit", {27'd0, status_word[4:0]}, 32'h02);
      chk("R2 irq raised", {31'd0, irq_o}, 32'd1);
      tick(3);
      chk("R4 sticky", {27'd0, status_word[4:0]}, 32'h02);
      ev_tx_space = 1'b1; tick(1); ev_tx_space = 1'b0;
      ev_rx_timeout = 1'b1; tick(1); ev_rx_timeout = 1'b0;
      chk("R2 several pending", {27'd0, status_word[4:0]}, 32'h0E);
      wr_stat(4'b0001, 32'h0000_0002);
      chk("R5 selective clear", {27'd0, status_word[4:0]}, 32'h0C);
      wr_stat(4'b0001, 32'h0000_000C);
      chk("R5 all cleared", {27'd0, status_word[4:0]}, 32'h00);
      chk("R2 irq dropped", {31'd0, irq_o}, 32'd0);
   endtask

   task automatic t_mask;
      wr_cfg(4'b0001, 32'h0000_000C);
      ev_rx_avail = 1'b1; ev_rx_timeout = 1'b1; ev_tx_space = 1'b1; tick(1);
      ev_rx_avail = 1'b0; ev_rx_timeout = 1'b0; ev_tx_space = 1'b0;
      chk("R3 rx and tx masked", {27'd0, status_word[4:0]}, 32'h00);
      chk("R3 no irq when masked", {31'd0, irq_o}, 32'd0);
      wr_cfg(4'b0001, 32'h0000_000F);
   endtask

   task automatic t_lsr;
      err_parity = 1'b1; tick(1); err_parity = 1'b0;
      chk("R6 parity flag", {24'd0, status_word[23:16]}, 32'h04);
      chk("R6 line cause", {27'd0, status_word[4:0]}, 32'h01);
      err_break = 1'b1; tick(1); err_break = 1'b0;
      lvl_data_ready = 1'b1; lvl_thr_empty = 1'b1; tick(1);
      chk("R6 live and sticky", {24'd0, status_word[23:16]}, 32'h35);
      wr_stat(4'b0001, 32'h0000_0001);
      chk("R6 errors cleared", {24'd0, status_word[23:16]}, 32'h21);
      chk("R6 line cause cleared", {27'd0, status_word[4:0]}, 32'h00);
      lvl_data_ready = 1'b0; lvl_thr_empty = 1'b0;
   endtask

   task automatic t_modem;
      modem_cts = 1'b1; tick(4);
      chk("R7 cts delta and level", {24'd0, status_word[15:8]}, 32'h11);
      chk("R7 modem cause", {27'd0, status_word[4:0]}, 32'h10);
      modem_dcd = 1'b1; tick(4);
      chk("R7 dcd added", {24'd0, status_word[15:8]}, 32'h99);
      wr_stat(4'b0001, 32'h0000_0010);
      chk("R7 deltas cleared", {24'd0, status_word[15:8]}, 32'h90);
      chk("R7 modem cause cleared", {31'd0, irq_o}, 32'd0);
   endtask

   task automatic t_fill;
      rx_fill = 10'h2A5; tick(1);
      chk("R10 fill split", {status_word[31:24], 16'd0, status_word[7:5], 5'd0}, 32'hA500_0080);
      ev_rx_avail = 1'b1; tick(1); ev_rx_avail = 1'b0;
      wr_stat(4'b1110, 32'hFFFF_FFFF);
      chk("R5 no lane 0 no clear", {27'd0, status_word[4:0]}, 32'h02);
      wr_stat(4'b0001, 32'h0000_00FF);
      chk("R5 upper bits immune", {status_word[31:24], 16'd0, status_word[7:0]}, 32'hA500_0080);
      rx_fill = '0;
   endtask

   task automatic t_race;
      ev_tx_space = 1'b1; tick(1);
      wr_stat(4'b0001, 32'h0000_0008);
      chk("R8 set wins", {27'd0, status_word[4:0]}, 32'h08);
      ev_tx_space = 1'b0;
      wr_stat(4'b0001, 32'h0000_0008);
      chk("R8 later clear", {27'd0, status_word[4:0]}, 32'h00);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_config();
      t_causes();
      t_mask();
      t_lsr();
      t_modem();
      t_fill();
      t_race();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule